// File: doc/BRIEF.md
# Two-Phase CCD Clock Sequencer

This block produces the digital clock pattern for a full-frame CCD that has a two-phase vertical (parallel) register and a two-phase horizontal (serial) register. A one-cycle start strobe launches one frame. A mode input selects how the frame is read. In full line binning, every row is shifted into the horizontal register before one line is read out. In area scanning, each single row shift is followed by a complete line readout, and this repeats for every row. A width input selects the pixel count of the short or the long sensor variant.

The horizontal register is isolated from the vertical register by a transfer gate, and the output node has a summing gate. The transfer gate always follows vertical phase 2, and the summing gate always follows horizontal phase 2. A reset gate pulse clears the output node once per pixel. A guard interval separates the end of vertical clocking from the first horizontal pulse. A pixel-valid flag marks the signal pixels of a line, and a one-cycle frame-done flag ends the frame. All timing is counted in master-clock cycles and set by parameters. The defaults give an 8-cycle vertical half period, a 3-cycle guard and a 4-cycle pixel, which match the intended timing at a 1 MHz master clock.

Top module: `ccd_clock_sequencer`

## Requirements
- R1: Each clock pair is complementary at all times (`v_ph2` = NOT `v_ph1`, `h_ph2` = NOT `h_ph1`). Outside a frame and during reset, every clock is at rest: both phase-1 outputs low, both phase-2 outputs and both gates high, `reset_gate` low.
- R2: `xfer_gate` always equals `v_ph2`, and `sum_gate` always equals `h_ph2`.
- R3: One vertical transfer lasts 2·VPW cycles. `v_ph1` is high for the first VPW cycles and low for the last VPW cycles.
- R4: With `bin_mode`=1, a frame makes ROWS vertical transfers back to back, then the guard interval, then exactly one line readout.
- R5: With `bin_mode`=0, a frame makes ROWS groups. Each group is one vertical transfer, then the guard interval, then one line readout.
- R6: A line has LEAD + ACT + TRAIL pixel periods of HPER cycles each. ACT is ACT_SHORT when `wide`=0 and ACT_LONG when `wide`=1. `h_ph1` is high for the first HPER/2 cycles of each pixel period.
- R7: After the last vertical transfer before a line ends, GUARD_CYC idle cycles pass before the first `h_ph1` rise. That rise therefore comes VPW+GUARD_CYC cycles after the last `v_ph1` fall. `h_ph1` and `v_ph1` are never high together.
- R8: `reset_gate` is high for exactly the first cycle of each pixel period, while `h_ph1` is high and the summing gate is still low.
- R9: `pix_valid` is high for the whole of pixel periods LEAD to LEAD+ACT−1 of each line (0-based) and low for the blank pixels on either side.
- R10: A start strobe is ignored while a frame is in progress. `bin_mode` and `wide` are sampled only at an accepted start, so later changes to them have no effect on the running frame.
- R11: `frame_done` is high for one cycle right after the last line. The frame then returns to rest. The strobe-to-done distance is ROWS·2·VPW+GUARD_CYC+NPIX·HPER+1 cycles in binning mode and ROWS·(2·VPW+GUARD_CYC+NPIX·HPER)+1 cycles in area mode.
- R12: While `rst_n` is low, all outputs are at rest and `pix_valid` and `frame_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle frame start strobe |
| bin_mode | input | 1 | 1 = full line binning, 0 = area scanning |
| wide | input | 1 | 1 = long sensor (ACT_LONG pixels), 0 = short sensor |
| v_ph1 | output | 1 | Vertical phase 1 |
| v_ph2 | output | 1 | Vertical phase 2 |
| xfer_gate | output | 1 | Transfer gate, same waveform as vertical phase 2 |
| h_ph1 | output | 1 | Horizontal phase 1 |
| h_ph2 | output | 1 | Horizontal phase 2 |
| sum_gate | output | 1 | Summing gate, same waveform as horizontal phase 2 |
| reset_gate | output | 1 | Output-node reset pulse, one per pixel |
| pix_valid | output | 1 | High during signal pixel periods |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The embedded properties assume that `start` is a strobe that drops before the running frame ends; a held level would start a new frame at once. They also assume parameters with HPER even and at least 2, VPW at least 1 and GUARD_CYC at least 1, which keeps the guard and pixel-phase relations meaningful. The stimulus drives `start` high for a single cycle. It changes `bin_mode` and `wide`, or pulses `start` again, only in the middle of a frame, where R10 says they must be ignored. The bench is built with small parameter overrides, so every mode and width combination runs to completion within the cycle budget.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_VSHIFT = 3'd1,
    SQ_GUARD  = 3'd2,
    SQ_READ   = 3'd3,
    SQ_DONE   = 3'd4
  } seq_state_e;

endpackage

// File: rtl/ccd_vclk_gen.sv
// Vertical transfer timer: one transfer = VPW cycles phase-1 high, VPW low.
module ccd_vclk_gen #(
  parameter int VPW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic v_ph1,
  output logic xfer_end
);

  localparam int XLEN = 2 * VPW;
  localparam int CW   = (XLEN > 1) ? $clog2(XLEN) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign xfer_end = run && (cnt_q == CW'(XLEN - 1));
  assign v_ph1    = run && (cnt_q < CW'(VPW));

  always_comb begin
    if (!run || xfer_end) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // phase 1 only starts a transfer from a cleared count
  AST_VPH1_STARTS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(v_ph1) |-> (cnt_q == '0)) else $error("vertical pulse misaligned"); // R3

endmodule

// File: rtl/ccd_hclk_gen.sv
// Horizontal line engine: pixel periods, reset gate, valid window.
module ccd_hclk_gen #(
  parameter int HPER      = 4,
  parameter int LEAD      = 10,
  parameter int TRAIL     = 10,
  parameter int ACT_SHORT = 512,
  parameter int ACT_LONG  = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic wide,
  output logic h_ph1,
  output logic reset_gate,
  output logic pix_valid,
  output logic line_end
);

  localparam int NPIX_S = LEAD + ACT_SHORT + TRAIL;
  localparam int NPIX_L = LEAD + ACT_LONG + TRAIL;
  localparam int NPIX_M = (NPIX_L > NPIX_S) ? NPIX_L : NPIX_S;
  localparam int PCW    = (HPER > 1) ? $clog2(HPER) : 1;
  localparam int NW     = $clog2(NPIX_M + 1);

  logic [PCW-1:0] ph_q, ph_d;
  logic [NW-1:0]  pix_q, pix_d;
  logic           per_end;
  logic           pix_last;
  logic [NW-1:0]  last_idx;
  logic [NW-1:0]  act_end;

  assign last_idx = wide ? NW'(NPIX_L - 1) : NW'(NPIX_S - 1);
  assign act_end  = wide ? NW'(LEAD + ACT_LONG) : NW'(LEAD + ACT_SHORT);
  assign per_end  = (ph_q == PCW'(HPER - 1));
  assign pix_last = (pix_q == last_idx);
  assign line_end = run && per_end && pix_last;

  assign h_ph1      = run && (ph_q < PCW'(HPER / 2));
  assign reset_gate = run && (ph_q == '0);
  assign pix_valid  = run && (pix_q >= NW'(LEAD)) && (pix_q < act_end);

  always_comb begin
    ph_d  = ph_q;
    pix_d = pix_q;
    if (!run) begin
      ph_d  = '0;
      pix_d = '0;
    end else if (per_end) begin
      ph_d  = '0;
      pix_d = pix_last ? '0 : pix_q + 1'b1;
    end else begin
      ph_d  = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      pix_q <= '0;
    end else begin
      ph_q  <= ph_d;
      pix_q <= pix_d;
    end
  end

  AST_RG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_gate |=> !reset_gate) else $error("reset gate wider than one cycle"); // R8
  AST_RG_IN_PH1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(h_ph1) |-> reset_gate) else $error("reset gate not at pixel start"); // R8

endmodule

// File: rtl/ccd_seq_ctrl.sv
// Frame sequencer: mode, row counting and guard interval.
module ccd_seq_ctrl
  import ccd_seq_pkg::*;
#(
  parameter int ROWS      = 128,
  parameter int GUARD_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic bin_mode,
  input  logic wide,
  input  logic xfer_end,
  input  logic line_end,
  output logic v_run,
  output logic h_run,
  output logic wide_cfg,
  output logic frame_done
);

  localparam int RW = $clog2(ROWS + 1);
  localparam int GW = $clog2(GUARD_CYC + 1);

  seq_state_e    st_q, st_d;
  logic [RW-1:0] row_q, row_d;
  logic [GW-1:0] gcnt_q, gcnt_d;
  logic          bin_q, bin_d;
  logic          wide_q, wide_d;

  assign v_run      = (st_q == SQ_VSHIFT);
  assign h_run      = (st_q == SQ_READ);
  assign frame_done = (st_q == SQ_DONE);
  assign wide_cfg   = wide_q;

  always_comb begin
    st_d   = st_q;
    row_d  = row_q;
    gcnt_d = gcnt_q;
    bin_d  = bin_q;
    wide_d = wide_q;
    unique case (st_q)
      SQ_IDLE: begin
        if (start) begin
          st_d   = SQ_VSHIFT;
          row_d  = '0;
          bin_d  = bin_mode;
          wide_d = wide;
        end
      end
      SQ_VSHIFT: begin
        if (xfer_end) begin
          row_d  = row_q + 1'b1;
          gcnt_d = '0;
          if (!bin_q || (row_q == RW'(ROWS - 1))) st_d = SQ_GUARD;
        end
      end
      SQ_GUARD: begin
        if (gcnt_q == GW'(GUARD_CYC - 1)) st_d = SQ_READ;
        else                              gcnt_d = gcnt_q + 1'b1;
      end
      SQ_READ: begin
        if (line_end) begin
          if (bin_q || (row_q == RW'(ROWS))) st_d = SQ_DONE;
          else                               st_d = SQ_VSHIFT;
        end
      end
      SQ_DONE: st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      row_q  <= '0;
      gcnt_q <= '0;
      bin_q  <= 1'b0;
      wide_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      row_q  <= row_d;
      gcnt_q <= gcnt_d;
      bin_q  <= bin_d;
      wide_q <= wide_d;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done) else $error("frame done longer than one cycle"); // R11
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != SQ_IDLE && $past(st_q) != SQ_IDLE) |-> ($stable(bin_q) && $stable(wide_q)))
    else $error("configuration changed inside a frame"); // R10
  AST_BIN_ALL_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (h_run && bin_q) |-> (row_q == RW'(ROWS))) else $error("binning readout before all rows"); // R4

endmodule

// File: rtl/ccd_clock_sequencer.sv
module ccd_clock_sequencer #(
  parameter int ROWS        = 128,
  parameter int VPW         = 8,
  parameter int GUARD_CYC   = 3,
  parameter int HPER        = 4,
  parameter int LEAD        = 10,
  parameter int TRAIL       = 10,
  parameter int ACT_SHORT   = 512,
  parameter int ACT_LONG    = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic bin_mode,
  input  logic wide,
  output logic v_ph1,
  output logic v_ph2,
  output logic xfer_gate,
  output logic h_ph1,
  output logic h_ph2,
  output logic sum_gate,
  output logic reset_gate,
  output logic pix_valid,
  output logic frame_done
);

  localparam int GAP_CAP = VPW + GUARD_CYC + 1;
  localparam int SW      = $clog2(GAP_CAP + 1);

  logic rst_n_i;
  logic v_run, h_run, wide_cfg;
  logic xfer_end, line_end;
  logic vph1_i, hph1_i;

  // reset: asserted asynchronously, released through a synchronizer
  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= 1'b1;
      end
      assign rst_n_i = sync_q;
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
      end
      assign rst_n_i = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  ccd_seq_ctrl #(
    .ROWS      (ROWS),
    .GUARD_CYC (GUARD_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .start      (start),
    .bin_mode   (bin_mode),
    .wide       (wide),
    .xfer_end   (xfer_end),
    .line_end   (line_end),
    .v_run      (v_run),
    .h_run      (h_run),
    .wide_cfg   (wide_cfg),
    .frame_done (frame_done)
  );

  ccd_vclk_gen #(
    .VPW (VPW)
  ) u_vclk (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .run      (v_run),
    .v_ph1    (vph1_i),
    .xfer_end (xfer_end)
  );

  ccd_hclk_gen #(
    .HPER      (HPER),
    .LEAD      (LEAD),
    .TRAIL     (TRAIL),
    .ACT_SHORT (ACT_SHORT),
    .ACT_LONG  (ACT_LONG)
  ) u_hclk (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .run        (h_run),
    .wide       (wide_cfg),
    .h_ph1      (hph1_i),
    .reset_gate (reset_gate),
    .pix_valid  (pix_valid),
    .line_end   (line_end)
  );

  assign v_ph1     = vph1_i;
  assign v_ph2     = ~vph1_i;
  assign xfer_gate = ~vph1_i;
  assign h_ph1     = hph1_i;
  assign h_ph2     = ~hph1_i;
  assign sum_gate  = ~hph1_i;

  // checker state: cycles since vertical phase 1 was last high
  logic [SW-1:0] vgap_q, vgap_d;
  always_comb begin
    if (vph1_i)                     vgap_d = '0;
    else if (vgap_q == SW'(GAP_CAP)) vgap_d = vgap_q;
    else                            vgap_d = vgap_q + 1'b1;
  end
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) vgap_q <= SW'(GAP_CAP);
    else          vgap_q <= vgap_d;
  end

  AST_GUARD_GAP: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(hph1_i) |-> (vgap_q >= SW'(GUARD_CYC))) else $error("guard interval violated"); // R7
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n_i)
    hph1_i |-> !vph1_i) else $error("vertical and horizontal clocks overlap"); // R7
  AST_VALID_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n_i)
    pix_valid |-> !vph1_i) else $error("pixel valid during vertical shift"); // R9

endmodule

// File: tb/tb_ccd_clock_sequencer.sv
module tb_ccd_clock_sequencer;

  localparam int ROWS  = 4;
  localparam int VPW   = 3;
  localparam int GRD   = 2;
  localparam int HPER  = 4;
  localparam int LEAD  = 2;
  localparam int TRAIL = 2;
  localparam int ACTS  = 4;
  localparam int ACTL  = 8;
  localparam int NPS   = LEAD + ACTS + TRAIL;
  localparam int NPL   = LEAD + ACTL + TRAIL;

  typedef struct {
    int vp;
    int hp;
    int rgp;
    int valid;
    int first;
  } line_t;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start, bin_mode, wide;
  logic v_ph1, v_ph2, xfer_gate, h_ph1, h_ph2, sum_gate, reset_gate, pix_valid, frame_done;

  ccd_clock_sequencer #(
    .ROWS(ROWS), .VPW(VPW), .GUARD_CYC(GRD), .HPER(HPER), .LEAD(LEAD),
    .TRAIL(TRAIL), .ACT_SHORT(ACTS), .ACT_LONG(ACTL), .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bin_mode(bin_mode), .wide(wide),
    .v_ph1(v_ph1), .v_ph2(v_ph2), .xfer_gate(xfer_gate), .h_ph1(h_ph1),
    .h_ph2(h_ph2), .sum_gate(sum_gate), .reset_gate(reset_gate),
    .pix_valid(pix_valid), .frame_done(frame_done)
  );

  int n_checks = 0;
  int n_fail   = 0;
  line_t exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // ---------------- monitor ----------------
  bit mon_en = 1'b0;
  bit in_line = 1'b0;
  bit pv, ph, prg, ppv;
  int vcount = 0, hp = 0, rgp = 0, vld = 0, first = -1;
  int since = 0, vlen = 0, hlen = 0;
  int compl_err = 0, gate_err = 0, vw_err = 0, hw_err = 0, rg_err = 0;

  task automatic close_line();
    line_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, "R5", "unexpected line", hp, 0);
    end else begin
      e = exp_q.pop_front();
      check(vcount == e.vp, "R4", "vertical transfers before line", vcount, e.vp);
      check(hp == e.hp, "R6", "pixel periods in line", hp, e.hp);
      check(rgp == e.rgp, "R8", "reset gate pulses in line", rgp, e.rgp);
      check(vld == e.valid, "R9", "valid cycles in line", vld, e.valid);
      check(first == e.first, "R9", "first valid pixel index", first, e.first);
    end
    in_line = 1'b0;
    vcount = 0; hp = 0; rgp = 0; vld = 0; first = -1;
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      bit vrise, vfall, hrise, rgrise;
      vrise  = v_ph1 && !pv;
      vfall  = !v_ph1 && pv;
      hrise  = h_ph1 && !ph;
      rgrise = reset_gate && !prg;
      if (vrise && in_line) close_line();
      if (vrise) vcount++;
      if (vfall) since = 0; else since++;
      if (hrise && !in_line) begin
        in_line = 1'b1;
        check(since == VPW + GRD, "R7", "gap last vertical edge to first h pulse", since, VPW + GRD);
      end
      if (in_line) begin
        if (hrise) hp++;
        if (rgrise) rgp++;
        if (pix_valid) vld++;
        if (pix_valid && !ppv) first = hp - 1;
      end
      if (frame_done && in_line) close_line();
      if (frame_done) vcount = 0;
      // R1 / R2 continuous relations
      if (v_ph2 !== ~v_ph1 || h_ph2 !== ~h_ph1) compl_err++;
      if (xfer_gate !== v_ph2 || sum_gate !== h_ph2) gate_err++;
      if (v_ph1 && h_ph1) compl_err++;
      // R3 vertical pulse width
      if (v_ph1) vlen++;
      else begin
        if (pv && vlen != VPW) vw_err++;
        vlen = 0;
      end
      // R6 horizontal high width
      if (h_ph1) hlen++;
      else begin
        if (ph && hlen != HPER / 2) hw_err++;
        hlen = 0;
      end
      // R8 reset gate single cycle at pixel start
      if (reset_gate && (prg || !h_ph1)) rg_err++;
      if (rgrise != hrise) rg_err++;
      pv = v_ph1; ph = h_ph1; prg = reset_gate; ppv = pix_valid;
    end
  end

  // ---------------- driver ----------------
  task automatic run_frame(input bit bin, input bit wd, input bit glitch);
    int npix, act, flen, n, lines, hit;
    line_t it;
    npix = wd ? NPL : NPS;
    act  = wd ? ACTL : ACTS;
    lines = bin ? 1 : ROWS;
    it.vp = bin ? ROWS : 1;
    it.hp = npix; it.rgp = npix; it.valid = act * HPER; it.first = LEAD;
    for (int i = 0; i < lines; i++) exp_q.push_back(it);
    flen = bin ? (ROWS * 2 * VPW + GRD + npix * HPER + 1)
               : (ROWS * (2 * VPW + GRD + npix * HPER) + 1);
    @(negedge clk);
    bin_mode = bin; wide = wd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!frame_done && n < 5000) begin
      if (glitch && n == 10) begin
        start = 1'b1; bin_mode = !bin; wide = !wd;
      end else if (glitch && n == 11) begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    if (n >= 5000) check(1'b0, "R11", "watchdog: frame never finished", n, flen);
    else check(n == flen, glitch ? "R10" : "R11", "start to frame done cycles", n, flen);
    @(negedge clk);
    check(frame_done == 1'b0, "R11", "frame done width", int'(frame_done), 0);
    check({v_ph1, v_ph2, xfer_gate, h_ph1, h_ph2, sum_gate, reset_gate, pix_valid} == 8'b0110_1100,
          "R1", "rest levels after frame",
          int'({v_ph1, v_ph2, xfer_gate, h_ph1, h_ph2, sum_gate, reset_gate, pix_valid}), 8'h6C);
    check(exp_q.size() == 0, bin ? "R4" : "R5", "expected lines not seen", exp_q.size(), 0);
    if (glitch) begin
      hit = 0;
      repeat (20) begin
        @(negedge clk);
        if (v_ph1 || h_ph1 || frame_done) hit++;
      end
      check(hit == 0, "R10", "activity after frame with ignored strobe", hit, 0);
    end
    exp_q.delete();
    bin_mode = 1'b0; wide = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; bin_mode = 1'b0; wide = 1'b0;
    repeat (3) @(negedge clk);
    check({v_ph1, v_ph2, xfer_gate, h_ph1, h_ph2, sum_gate, reset_gate, pix_valid, frame_done} == 9'b0110_1100_0,
          "R12", "outputs in reset",
          int'({v_ph1, v_ph2, xfer_gate, h_ph1, h_ph2, sum_gate, reset_gate, pix_valid, frame_done}), 9'h0D8);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    pv = v_ph1; ph = h_ph1; prg = reset_gate; ppv = pix_valid;
    mon_en = 1'b1;
    run_frame(1'b1, 1'b0, 1'b0);   // R4 binning, short
    run_frame(1'b1, 1'b1, 1'b0);   // R4 binning, long
    run_frame(1'b0, 1'b0, 1'b0);   // R5 area, short
    run_frame(1'b0, 1'b1, 1'b1);   // R5 R10 area, long, inputs disturbed
    run_frame(1'b1, 1'b0, 1'b1);   // R4 R10 binning, short, inputs disturbed
    repeat (4) @(negedge clk);
    check(compl_err == 0, "R1", "complementary phase violations", compl_err, 0);
    check(gate_err == 0, "R2", "gate copy violations", gate_err, 0);
    check(vw_err == 0, "R3", "vertical pulse width errors", vw_err, 0);
    check(hw_err == 0, "R6", "horizontal high width errors", hw_err, 0);
    check(rg_err == 0, "R8", "reset gate placement errors", rg_err, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    check(1'b0, "R11", "global watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule